// File: doc/BRIEF.md
# Processor Reset and Strap Configuration Sequencer

This block runs on the system bus clock. It produces the active-low reset for a processor and controls when the processor's strap configuration pins are driven around that reset. It has two pin groups. The first is a 5-bit bus ratio value. The second is a group of extra configuration values of parameterised width. Each group has its own output enable. The sequencer makes sure each group is valid for the required clock window on both sides of the reset release.

A cold sequence starts when power-good is seen high. A warm sequence starts when a warm request arrives after a completed sequence, while power-good is already high. In both cases reset is held low for a fixed cycle count that stands for 1 ms at the bus clock frequency. The extra configuration pins are enabled a set number of clocks before release. Both groups stay driven for a short hold after release and are then let go, and a done flag rises. If power-good drops at any point, the cold sequence starts again. The pin values are captured when a sequence starts, so the driven pins stay constant until that sequence ends.

Top module: `reset_cfg_seq`

## Requirements
- R1: While the block's own reset is low, and while power-good is low, the processor reset output is low, the ratio enable is high, the extra enable is low and done is low. In this waiting state the ratio pins follow the ratio input with one clock of delay.
- R2: The first clock after power-good is sampled high in the waiting state, or after an accepted warm request, starts the reset window. In that window the processor reset stays low for exactly RST_CYCLES = CLK_KHZ clocks, then goes high.
- R3: The ratio enable is high in every clock in which the processor reset output is low.
- R4: The extra configuration enable is high for exactly the last PRE_CLKS (at least 4) clocks of the reset window, and low for the rest of it.
- R5: After reset rises, both enables stay high for exactly HOLD_CLKS (2) clocks. Both then go low.
- R6: When done is high and power-good is high, a warm request sampled on a clock edge makes the processor reset output low in the next clock.
- R7: A warm request sampled while done is low has no effect. The reset window length and the enable timing stay unchanged.
- R8: Power-good sampled low on an edge puts the block in the waiting state of R1 on the next clock, whatever state it was in before.
- R9: The ratio value and the extra value are captured on the edge that starts a sequence. While their enables are high outside the waiting state, the pins show the captured values, even if the inputs change.
- R10: Done is high only after the hold, and it stays high until the next sequence. While done is high, reset is high and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| pwr_good_i | input | 1 | Power-good indication |
| warm_req_i | input | 1 | Warm reset request |
| ratio_i | input | 5 | Bus ratio value to drive |
| xcfg_i | input | XW | Extra configuration values to drive |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| ratio_o | output | 5 | Driven bus ratio value |
| ratio_oe_o | output | 1 | Ratio pin output enable |
| xcfg_o | output | XW | Driven extra configuration values |
| xcfg_oe_o | output | 1 | Extra configuration output enable |
| done_o | output | 1 | Sequence complete |

## Verification
Cold sequences are started by a rising power-good and warm sequences by requests made after done. The window lengths measured in the two cases must match, which separates a shared counter from a per-path one. Random configuration values are driven and then changed in the middle of each window, which shows whether the pins come from the captured register or from the live inputs. Random warm pulses during a window separate ignored requests from restarts. Power-good is dropped in the middle of the reset window and again during the hold, to check that every state returns to the waiting state.

// File: rtl/rcs_pkg.sv
// Package for the reset configuration sequencer.
// It holds the one-hot state type that the FSM and the top module share.
package rcs_pkg;

    // One-hot sequencer states
    typedef enum logic [4:0] {
        ST_IDLE   = 5'b00001,
        ST_ASSERT = 5'b00010,
        ST_PRE    = 5'b00100,
        ST_HOLD   = 5'b01000,
        ST_DONE   = 5'b10000
    } seq_state_t;

endpackage

// File: rtl/rcs_timer.sv
// Down-counter for the length of each timed state.
// A load sets the count to (length - 1). The counter then counts down to
// zero and stays there. Assumes the loaded value fits in CW bits.
module rcs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    // Load the count, or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rcs_cfg_latch.sv
// Capture registers for the ratio value and the extra configuration value.
// They load whenever cap_i is high and hold otherwise, so the pin values
// cannot change partway through a sequence.
module rcs_cfg_latch #(
    parameter int RW = 5,
    parameter int XW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [RW-1:0] ratio_i,
    input  logic [XW-1:0] xcfg_i,
    output logic [RW-1:0] ratio_q_o,
    output logic [XW-1:0] xcfg_q_o
);
    // Load both values together on a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q_o <= '0;
            xcfg_q_o  <= '0;
        end else if (cap_i) begin
            ratio_q_o <= ratio_i;
            xcfg_q_o  <= xcfg_i;
        end
    end
endmodule

// File: rtl/rcs_fsm.sv
// One-hot state machine of the sequencer.
// Power-good low sends every state to IDLE. IDLE goes to ASSERT when
// power-good is high. DONE goes to ASSERT on a warm request. ASSERT, PRE
// and HOLD each last the time their timer load gives them.
// Assumes ASSERT_CLKS, PRE_CLKS and HOLD_CLKS are all at least 1.
module rcs_fsm
    import rcs_pkg::*;
#(
    parameter int CW          = 8,
    parameter int ASSERT_CLKS = 36,
    parameter int PRE_CLKS    = 4,
    parameter int HOLD_CLKS   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good_i,
    input  logic          warm_req_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          cap_o,
    output seq_state_t    state_o
);
    localparam logic [CW-1:0] LdAssert = CW'(ASSERT_CLKS - 1);
    localparam logic [CW-1:0] LdPre    = CW'(PRE_CLKS - 1);
    localparam logic [CW-1:0] LdHold   = CW'(HOLD_CLKS - 1);

    seq_state_t state_q, state_d;

    // Next state and timer load
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (!pwr_good_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d    = ST_ASSERT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LdAssert;
                end
                ST_ASSERT: if (tmr_zero_i) begin
                    state_d    = ST_PRE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LdPre;
                end
                ST_PRE: if (tmr_zero_i) begin
                    state_d    = ST_HOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LdHold;
                end
                ST_HOLD: if (tmr_zero_i) begin
                    state_d = ST_DONE;
                end
                ST_DONE: if (warm_req_i) begin
                    state_d    = ST_ASSERT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LdAssert;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Capture pins while waiting, and on an accepted warm request
    assign cap_o = (state_q == ST_IDLE) || ((state_q == ST_DONE) && warm_req_i);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/reset_cfg_seq.sv
// Top of the processor reset and strap configuration sequencer.
// It drives the active-low processor reset and the two strap pin groups
// with their enables. The outputs are decoded from the registered one-hot
// state. Assumes CLK_KHZ > PRE_CLKS, PRE_CLKS >= 4 and HOLD_CLKS in 2..3.
module reset_cfg_seq
    import rcs_pkg::*;
#(
    parameter int CLK_KHZ   = 200_000,
    parameter int PRE_CLKS  = 4,
    parameter int HOLD_CLKS = 2,
    parameter int XW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good_i,
    input  logic          warm_req_i,
    input  logic [4:0]    ratio_i,
    input  logic [XW-1:0] xcfg_i,
    output logic          cpu_rst_n_o,
    output logic [4:0]    ratio_o,
    output logic          ratio_oe_o,
    output logic [XW-1:0] xcfg_o,
    output logic          xcfg_oe_o,
    output logic          done_o
);
    localparam int RW          = 5;
    localparam int RST_CYCLES  = CLK_KHZ;
    localparam int ASSERT_CLKS = RST_CYCLES - PRE_CLKS;
    localparam int CW          = $clog2(RST_CYCLES + 1);

    logic          tmr_load, tmr_zero, cap;
    logic [CW-1:0] tmr_val;
    seq_state_t    state;
    logic [RW-1:0] ratio_q;
    logic [XW-1:0] xcfg_q;

    rcs_fsm #(
        .CW(CW), .ASSERT_CLKS(ASSERT_CLKS),
        .PRE_CLKS(PRE_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i),
        .warm_req_i(warm_req_i), .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .cap_o(cap), .state_o(state)
    );

    rcs_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    rcs_cfg_latch #(.RW(RW), .XW(XW)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap_i(cap),
        .ratio_i(ratio_i), .xcfg_i(xcfg_i),
        .ratio_q_o(ratio_q), .xcfg_q_o(xcfg_q)
    );

    // Decode the pin controls from the one-hot state
    always_comb begin
        cpu_rst_n_o = (state == ST_HOLD) || (state == ST_DONE);
        ratio_oe_o  = (state != ST_DONE);
        xcfg_oe_o   = (state == ST_PRE) || (state == ST_HOLD);
        done_o      = (state == ST_DONE);
    end

    assign ratio_o = ratio_q;
    assign xcfg_o  = xcfg_q;
endmodule

// File: rtl/rcs_chk.sv
// Checker for reset_cfg_seq. It watches the ports only and is bound to
// every instance of the top module.
module rcs_chk #(
    parameter int PRE_CLKS = 4,
    parameter int XW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good_i,
    input logic          cpu_rst_n_o,
    input logic [4:0]    ratio_o,
    input logic          ratio_oe_o,
    input logic [XW-1:0] xcfg_o,
    input logic          xcfg_oe_o,
    input logic          done_o
);
    logic [15:0] pre_run_q;

    // Count consecutive clocks with reset low and the extra enable high
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_run_q <= '0;
        else if (!cpu_rst_n_o && xcfg_oe_o)
            pre_run_q <= pre_run_q + 16'd1;
        else
            pre_run_q <= '0;
    end

    // R3
    ratio_while_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst_n_o |-> ratio_oe_o);

    // R4
    pre_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> (pre_run_q == 16'(PRE_CLKS)));

    // R5
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_oe_o) |-> (done_o && cpu_rst_n_o && !xcfg_oe_o));

    // R8
    pg_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (!cpu_rst_n_o && ratio_oe_o && !xcfg_oe_o && !done_o));

    // R9
    ratio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_n_o && ratio_oe_o) |-> $stable(ratio_o));

    // R9
    xcfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xcfg_oe_o && $past(xcfg_oe_o)) |-> $stable(xcfg_o));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cpu_rst_n_o && !ratio_oe_o && !xcfg_oe_o));
endmodule

bind reset_cfg_seq rcs_chk #(.PRE_CLKS(PRE_CLKS), .XW(XW)) u_rcs_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i),
    .cpu_rst_n_o(cpu_rst_n_o), .ratio_o(ratio_o), .ratio_oe_o(ratio_oe_o),
    .xcfg_o(xcfg_o), .xcfg_oe_o(xcfg_oe_o), .done_o(done_o)
);

// File: tb/test_reset_cfg_seq.sv
// Bench for reset_cfg_seq. The 1 ms window is scaled down by a small CLK_KHZ.
module test_reset_cfg_seq;
    localparam int CLK_KHZ = 40;
    localparam int PRE     = 4;
    localparam int HOLD    = 2;
    localparam int XW      = 8;
    localparam int RSTC    = CLK_KHZ;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pg = 1'b0;
    logic          warm = 1'b0;
    logic [4:0]    ratio_in = '0;
    logic [XW-1:0] xcfg_in = '0;
    logic          cpu_rst_n, ratio_oe, xcfg_oe, done;
    logic [4:0]    ratio_out;
    logic [XW-1:0] xcfg_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    reset_cfg_seq #(.CLK_KHZ(CLK_KHZ), .PRE_CLKS(PRE), .HOLD_CLKS(HOLD), .XW(XW))
    i_reset_cfg_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .warm_req_i(warm),
        .ratio_i(ratio_in), .xcfg_i(xcfg_in),
        .cpu_rst_n_o(cpu_rst_n), .ratio_o(ratio_out), .ratio_oe_o(ratio_oe),
        .xcfg_o(xcfg_out), .xcfg_oe_o(xcfg_oe), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waiting-state pattern packed into one value: {rst_n, ratio_oe, xcfg_oe, done}
    function automatic int idle_pat();
        return 4'b0100;
    endfunction

    function automatic int cur_pat();
        return int'({cpu_rst_n, ratio_oe, xcfg_oe, done});
    endfunction

    // Follow one sequence from its first reset-low clock to done
    task automatic measure(input logic [4:0] er, input logic [XW-1:0] ex,
                           input bit inject);
        int nlow = 0, npre = 0, nhold = 0, bad3 = 0, bad9 = 0, guard = 0;
        bit last_x = 1'b0, early_x = 1'b0;
        chk(!cpu_rst_n, "R2/R6 reset low at start", int'(cpu_rst_n), 0);
        while (!done && guard < 500) begin
            guard++;
            if (!cpu_rst_n) begin
                nlow++;
                if (!ratio_oe) bad3++;
                if (xcfg_oe) npre++;
                if (last_x && !xcfg_oe) early_x = 1'b1;
                last_x = xcfg_oe;
            end else if (ratio_oe && xcfg_oe) begin
                nhold++;
            end
            if (ratio_oe && ratio_out != er) bad9++;
            if (xcfg_oe && xcfg_out != ex) bad9++;
            if (inject) begin
                ratio_in = 5'($urandom);
                xcfg_in  = XW'($urandom);
                warm     = ($urandom % 6) == 0;
            end
            @(negedge clk);
        end
        warm = 1'b0;
        chk(nlow == RSTC, "R2 reset window length", nlow, RSTC);
        chk(bad3 == 0, "R3 ratio enable during reset", bad3, 0);
        chk(npre == PRE && last_x && !early_x, "R4 extra enable window", npre, PRE);
        chk(nhold == HOLD, "R5 hold after release", nhold, HOLD);
        chk(bad9 == 0, "R9 captured values held", bad9, 0);
        chk(cur_pat() == 4'b1001, "R10 done state outputs", cur_pat(), 4'b1001);
        if (inject)
            chk(nlow == RSTC, "R7 warm during sequence ignored", nlow, RSTC);
    endtask

    task automatic cold_seq(input bit inject);
        logic [4:0]    r = 5'($urandom);
        logic [XW-1:0] x = XW'($urandom);
        ratio_in = r; xcfg_in = x;
        @(negedge clk);
        pg = 1'b1;
        @(negedge clk);
        measure(r, x, inject);
    endtask

    task automatic warm_seq(input bit inject);
        logic [4:0]    r = 5'($urandom);
        logic [XW-1:0] x = XW'($urandom);
        ratio_in = r; xcfg_in = x; warm = 1'b1;
        @(negedge clk);
        warm = 1'b0;
        chk(!cpu_rst_n, "R6 warm accepted next clock", int'(cpu_rst_n), 0);
        measure(r, x, inject);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        ratio_in = 5'd9;
        repeat (3) @(negedge clk);
        chk(cur_pat() == idle_pat(), "R1 outputs during block reset", cur_pat(), idle_pat());
        rst_n = 1'b1;
        ratio_in = 5'd21;
        repeat (3) @(negedge clk);
        chk(cur_pat() == idle_pat(), "R1 waiting for power", cur_pat(), idle_pat());
        chk(ratio_out == 5'd21, "R1 ratio follows input while waiting", int'(ratio_out), 21);

        // Directed cold then warm, no disturbance
        cold_seq(1'b0);
        repeat (3) @(negedge clk);
        chk(done && cpu_rst_n, "R10 done holds", cur_pat(), 4'b1001);
        warm_seq(1'b0);

        // Power lost in the middle of the reset window
        warm = 1'b1; @(negedge clk); warm = 1'b0;
        repeat (10) @(negedge clk);
        pg = 1'b0;
        @(negedge clk);
        chk(cur_pat() == idle_pat(), "R8 power loss in reset window", cur_pat(), idle_pat());
        cold_seq(1'b0);

        // Power lost during the hold
        warm = 1'b1; @(negedge clk); warm = 1'b0;
        while (!cpu_rst_n) @(negedge clk);
        pg = 1'b0;
        @(negedge clk);
        chk(cur_pat() == idle_pat(), "R8 power loss during hold", cur_pat(), idle_pat());
        cold_seq(1'b1);

        // Random mix of warm and cold sequences with disturbances
        for (int i = 0; i < 10; i++) begin
            if ($urandom % 2) begin
                warm_seq(1'b1);
            end else begin
                pg = 1'b0;
                repeat (1 + $urandom % 3) @(negedge clk);
                chk(cur_pat() == idle_pat(), "R8 power low", cur_pat(), idle_pat());
                cold_seq(1'b1);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule